// File: doc/BRIEF.md
# Stereo Digital Attenuator With Soft Mute

This block scales a stream of signed left and right audio samples by a per-channel attenuation code. Codes count downward from unity gain in half-decibel steps, and the all-ones code silences the channel. Every sample is presented with a one-cycle strobe. The scaled pair comes out registered, with its own strobe one clock later. A link input lets the left code drive both channels. A code change is never applied in one jump. The working level of each channel moves one code per sample toward the new setting, so the output steps gently.

A soft-mute request ramps both channels from their working level to silence over a selectable number of sample periods. Dropping the request runs the same ramp backwards. While a ramp is under way or held, the working levels are frozen. A code written during that time takes effect only once the channels are back at their working level.

Top module: `atten_stereo`

## Requirements
- R1: For a code c below 255 the linear gain, in units of 2^-16, is B[c mod 12] shifted right by floor(c/12), where B[k] = round(65536 * 10^(-k/40)); code 255 gives gain 0 and a zero output.
- R2: On a clock edge with smp_stb high, each output becomes (x*g + 32768) >> 16 (arithmetic shift, so rounding is half-up), saturated to the signed 16-bit range. smp_out_stb is high for exactly the following cycle.
- R3: With link_en = 1 both channels aim at atten_l; with link_en = 0 the right channel aims at atten_r.
- R4: With no soft-mute activity, each strobe moves a channel's working level one code toward its target. The sample on that strobe is scaled with the level held before the step.
- R5: mute_time selects the ramp length N: 00 gives 1024, 01 gives 512, 10 gives 256, 11 gives 128 sample periods. A zeroed field therefore selects 1024.
- R6: A ramp phase p rises by one on each strobe while softmute is high, up to N. The strobe k-th after the request, counted from 0, uses p = k. The code applied is L + floor((255 - L) * p / N), where L is the working level, so p = N gives mute.
- R7: With softmute low and p above 0, p falls by one per strobe, reversing the ramp back to L. A phase above a newly shortened N is first clamped to N.
- R8: While softmute is high or p is not 0, the working levels hold even if the codes change. The new code is tracked from the first strobe with p = 0 and softmute low.
- R9: After reset the outputs are 0, smp_out_stb is 0, the working levels are 0 (unity gain) and p is 0.
- R10: Cycles without smp_stb change neither the outputs nor the working levels nor the ramp phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample pair |
| smp_l_in | input | 16 | Left input sample, two's complement |
| smp_r_in | input | 16 | Right input sample, two's complement |
| atten_l | input | 8 | Left attenuation code (0.5 dB per count, 255 mute) |
| atten_r | input | 8 | Right attenuation code |
| link_en | input | 1 | 1: left code controls both channels |
| softmute | input | 1 | Soft-mute request |
| mute_time | input | 2 | Ramp length select |
| smp_l_out | output | 16 | Attenuated left sample |
| smp_r_out | output | 16 | Attenuated right sample |
| smp_out_stb | output | 1 | High for the cycle after a strobe; outputs valid |

## Verification
The bench writes a code while the channels are fully muted. A design that let the level track during the ramp would come back from mute at the new code instead of the old one. It shortens the ramp length while the phase sits at 1024. A design without the clamp would come back from an out-of-range phase and produce a code beyond mute, or an output that is no longer silent on the first released sample. It walks codes across the 12-step octave boundary and up to the last audible code. There, a wrong remainder or shift in the gain lookup shows up as an output off by several counts. It also feeds full-scale negative input and -1. A design that truncated instead of rounding would return the wrong value for odd products.

// File: rtl/atten_pkg.sv
package atten_pkg;
  // Gain is unsigned fixed point with GAIN_FRAC fraction bits; 1.0 needs one more bit.
  localparam int GAIN_FRAC = 16;
  localparam int GAIN_W = GAIN_FRAC + 1;
  // Twelve half-dB steps make one (near) halving of the gain.
  localparam int STEPS_PER_OCT = 12;

  // 65536 * 10^(-k/40), rounded, for the twelve steps inside one octave.
  function automatic logic [GAIN_W-1:0] base_gain(input int unsigned k);
    case (k)
      0:       return 17'd65536;
      1:       return 17'd61870;
      2:       return 17'd58409;
      3:       return 17'd55142;
      4:       return 17'd52057;
      5:       return 17'd49145;
      6:       return 17'd46396;
      7:       return 17'd43801;
      8:       return 17'd41350;
      9:       return 17'd39037;
      10:      return 17'd36854;
      11:      return 17'd34792;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/atten_level_track.sv
module atten_level_track #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              hold,
  input  logic [CODE_W-1:0] target,
  output logic [CODE_W-1:0] level
);
  // One code per sample toward the target; frozen while a mute ramp is active.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
    end else if (stb && !hold) begin
      if (level < target) begin
        level <= level + CODE_W'(1);
      end else if (level > target) begin
        level <= level - CODE_W'(1);
      end
    end
  end
endmodule

// File: rtl/atten_mute_seq.sv
module atten_mute_seq #(
  parameter int TLOG_MAX = 10,
  parameter int TIME_W   = 2,
  parameter int PH_W     = TLOG_MAX + 1,
  parameter int SH_W     = $clog2(TLOG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              mute_req,
  input  logic [TIME_W-1:0] mute_time,
  output logic [PH_W-1:0]   ph_q,
  output logic [PH_W-1:0]   ph_use,
  output logic [PH_W-1:0]   n_sel,
  output logic [SH_W-1:0]   sh,
  output logic              ph_full,
  output logic              ramp_active
);
  // Ramp length is 2^sh periods; a zero field gives the longest ramp.
  assign sh      = SH_W'(TLOG_MAX) - SH_W'(mute_time);
  assign n_sel   = PH_W'(1) << sh;
  // A phase left above a shortened ramp is treated as the full ramp.
  assign ph_use  = (ph_q > n_sel) ? n_sel : ph_q;
  assign ph_full = (ph_use == n_sel);
  assign ramp_active = mute_req || (ph_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (stb) begin
      if (mute_req) begin
        ph_q <= ph_full ? n_sel : ph_use + PH_W'(1);
      end else begin
        ph_q <= (ph_use == '0) ? '0 : ph_use - PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/atten_chan_scale.sv
module atten_chan_scale
  import atten_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CODE_W = 8,
  parameter int PH_W   = 11,
  parameter int SH_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stb,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic [CODE_W-1:0]        level,
  input  logic [PH_W-1:0]          ph,
  input  logic [SH_W-1:0]          sh,
  output logic [CODE_W-1:0]        eff,
  output logic signed [DATA_W-1:0] y_out
);
  localparam logic [CODE_W-1:0] MUTE = '1;
  localparam int SPAN_W = CODE_W + PH_W;
  localparam int PW     = DATA_W + GAIN_W + 1;

  // Code applied at phase ph of a ramp of 2^sh periods starting from lvl.
  function automatic logic [CODE_W-1:0] ramp_code(input logic [CODE_W-1:0] lvl,
                                                  input logic [PH_W-1:0]   p,
                                                  input logic [SH_W-1:0]   s);
    logic [SPAN_W-1:0] span;
    span = SPAN_W'(MUTE - lvl) * SPAN_W'(p);
    return lvl + CODE_W'(span >> s);
  endfunction

  // Linear gain for a code: octave shift of a twelve-entry base.
  function automatic logic [GAIN_W-1:0] gain_of(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] oct;
    logic [CODE_W-1:0] rem;
    oct = c / CODE_W'(STEPS_PER_OCT);
    rem = c % CODE_W'(STEPS_PER_OCT);
    if (c == MUTE) begin
      return '0;
    end
    return base_gain(32'(rem)) >> oct;
  endfunction

  // Signed multiply, round half-up, saturate to the sample width.
  function automatic logic signed [DATA_W-1:0] scale_sample(
      input logic signed [DATA_W-1:0] x, input logic [GAIN_W-1:0] g);
    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] ge;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;
    logic signed [PW-1:0] shr;
    logic signed [PW-1:0] half;
    xe   = {{(PW-DATA_W){x[DATA_W-1]}}, x};
    ge   = {{(PW-GAIN_W){1'b0}}, g};
    half = PW'(1) <<< (GAIN_FRAC - 1);
    prod = xe * ge;
    rnd  = prod + half;
    shr  = rnd >>> GAIN_FRAC;
    if (!shr[PW-1] && (|shr[PW-2:DATA_W-1])) begin
      return {1'b0, {(DATA_W-1){1'b1}}};
    end else if (shr[PW-1] && !(&shr[PW-2:DATA_W-1])) begin
      return {1'b1, {(DATA_W-1){1'b0}}};
    end
    return shr[DATA_W-1:0];
  endfunction

  assign eff = ramp_code(level, ph, sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_out <= '0;
    end else if (stb) begin
      y_out <= scale_sample(x_in, gain_of(eff));
    end
  end
endmodule

// File: rtl/atten_stereo.sv
module atten_stereo #(
  parameter int DATA_W   = 16,
  parameter int CODE_W   = 8,
  parameter int TLOG_MAX = 10,
  parameter int TIME_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_stb,
  input  logic signed [DATA_W-1:0] smp_l_in,
  input  logic signed [DATA_W-1:0] smp_r_in,
  input  logic [CODE_W-1:0]        atten_l,
  input  logic [CODE_W-1:0]        atten_r,
  input  logic                     link_en,
  input  logic                     softmute,
  input  logic [TIME_W-1:0]        mute_time,
  output logic signed [DATA_W-1:0] smp_l_out,
  output logic signed [DATA_W-1:0] smp_r_out,
  output logic                     smp_out_stb
);
  localparam int PH_W = TLOG_MAX + 1;
  localparam int SH_W = $clog2(TLOG_MAX + 1);
  localparam int NCH  = 2;

  logic [PH_W-1:0] ph_q, ph_use, n_sel;
  logic [SH_W-1:0] sh;
  logic            ph_full, ramp_active;

  logic [CODE_W-1:0]        tgt_a [NCH];
  logic [CODE_W-1:0]        lvl_a [NCH];
  logic [CODE_W-1:0]        eff_a [NCH];
  logic signed [DATA_W-1:0] x_a   [NCH];
  logic signed [DATA_W-1:0] y_a   [NCH];

  // Named per-channel views for the checker.
  logic [CODE_W-1:0] tgt_l, tgt_r, lvl_l, lvl_r, eff_l, eff_r;

  assign tgt_a[0] = atten_l;
  assign tgt_a[1] = link_en ? atten_l : atten_r;
  assign x_a[0]   = smp_l_in;
  assign x_a[1]   = smp_r_in;

  atten_mute_seq #(
    .TLOG_MAX(TLOG_MAX), .TIME_W(TIME_W), .PH_W(PH_W), .SH_W(SH_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .stb(smp_stb), .mute_req(softmute),
    .mute_time(mute_time), .ph_q(ph_q), .ph_use(ph_use), .n_sel(n_sel),
    .sh(sh), .ph_full(ph_full), .ramp_active(ramp_active)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    atten_level_track #(.CODE_W(CODE_W)) u_track (
      .clk(clk), .rst_n(rst_n), .stb(smp_stb), .hold(ramp_active),
      .target(tgt_a[c]), .level(lvl_a[c])
    );
    atten_chan_scale #(
      .DATA_W(DATA_W), .CODE_W(CODE_W), .PH_W(PH_W), .SH_W(SH_W)
    ) u_scale (
      .clk(clk), .rst_n(rst_n), .stb(smp_stb), .x_in(x_a[c]),
      .level(lvl_a[c]), .ph(ph_use), .sh(sh), .eff(eff_a[c]), .y_out(y_a[c])
    );
  end

  assign tgt_l = tgt_a[0];
  assign tgt_r = tgt_a[1];
  assign lvl_l = lvl_a[0];
  assign lvl_r = lvl_a[1];
  assign eff_l = eff_a[0];
  assign eff_r = eff_a[1];
  assign smp_l_out = y_a[0];
  assign smp_r_out = y_a[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_out_stb <= 1'b0;
    end else begin
      smp_out_stb <= smp_stb;
    end
  end
endmodule

// File: rtl/atten_stereo_chk.sv
module atten_stereo_chk #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 8,
  parameter int PH_W   = 11
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     smp_stb,
  input logic                     softmute,
  input logic                     link_en,
  input logic                     out_stb,
  input logic signed [DATA_W-1:0] out_l,
  input logic signed [DATA_W-1:0] out_r,
  input logic [CODE_W-1:0]        tgt_l,
  input logic [CODE_W-1:0]        tgt_r,
  input logic [CODE_W-1:0]        lvl_l,
  input logic [CODE_W-1:0]        lvl_r,
  input logic [CODE_W-1:0]        eff_l,
  input logic [CODE_W-1:0]        eff_r,
  input logic [PH_W-1:0]          ph_q,
  input logic [PH_W-1:0]          ph_use,
  input logic [PH_W-1:0]          n_sel,
  input logic                     ph_full,
  input logic                     ramp_active
);
  localparam logic [CODE_W-1:0] MUTE = '1;

  p_mute_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && eff_l == MUTE && eff_r == MUTE) |=> (out_l == '0 && out_r == '0));

  p_out_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> out_stb);

  p_link_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && link_en && !ramp_active && lvl_l == lvl_r && tgt_l == tgt_r)
      |=> lvl_l == lvl_r);

  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !ramp_active && lvl_l < tgt_l) |=> lvl_l == CODE_W'($past(lvl_l) + 1'b1));

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !ramp_active && lvl_r > tgt_r) |=> lvl_r == CODE_W'($past(lvl_r) - 1'b1));

  p_at_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_use == '0) |-> (eff_l == lvl_l && eff_r == lvl_r));

  p_ramp_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && softmute && ph_use < n_sel) |=> ph_q == PH_W'($past(ph_use) + 1'b1));

  p_full_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ph_full |-> (eff_l == MUTE && eff_r == MUTE));

  p_ramp_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !softmute && ph_use != '0) |=> ph_q == PH_W'($past(ph_use) - 1'b1));

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && ramp_active) |=> ($stable(lvl_l) && $stable(lvl_r)));

  p_idle_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> (!out_stb && $stable(out_l) && $stable(out_r)));

  p_idle_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(ph_q) && $stable(lvl_l) && $stable(lvl_r)));
endmodule

bind atten_stereo atten_stereo_chk #(
  .DATA_W(DATA_W), .CODE_W(CODE_W), .PH_W(PH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .softmute(softmute),
  .link_en(link_en), .out_stb(smp_out_stb), .out_l(smp_l_out),
  .out_r(smp_r_out), .tgt_l(tgt_l), .tgt_r(tgt_r), .lvl_l(lvl_l),
  .lvl_r(lvl_r), .eff_l(eff_l), .eff_r(eff_r), .ph_q(ph_q),
  .ph_use(ph_use), .n_sel(n_sel), .ph_full(ph_full),
  .ramp_active(ramp_active)
);

// File: tb/tb_atten_stereo.sv
module tb_atten_stereo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic signed [15:0] smp_l_in = '0, smp_r_in = '0;
  logic [7:0] atten_l = '0, atten_r = '0;
  logic link_en = 1'b0, softmute = 1'b0;
  logic [1:0] mute_time = 2'b00;
  logic signed [15:0] smp_l_out, smp_r_out;
  logic smp_out_stb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  atten_stereo dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_l_in(smp_l_in),
    .smp_r_in(smp_r_in), .atten_l(atten_l), .atten_r(atten_r),
    .link_en(link_en), .softmute(softmute), .mute_time(mute_time),
    .smp_l_out(smp_l_out), .smp_r_out(smp_r_out), .smp_out_stb(smp_out_stb)
  );

  typedef struct packed {
    logic signed [15:0] sl;
    logic signed [15:0] sr;
    logic [7:0]         cl;
    logic [7:0]         cr;
    logic               lk;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{ 16'sd20000, -16'sd20000, 8'd0,   8'd0,   1'b0},
    '{ 16'sd1001,  -16'sd1001,  8'd12,  8'd12,  1'b0},
    '{ 16'sd32767, -16'sd32768, 8'd0,   8'd24,  1'b0},
    '{ 16'sd10000,  16'sd10000, 8'd1,   8'd7,   1'b0},
    '{-16'sd12345,  16'sd5000,  8'd30,  8'd255, 1'b0},
    '{ 16'sd30000,  16'sd30000, 8'd24,  8'd0,   1'b1},
    '{-16'sd30000,  16'sd20000, 8'd255, 8'd3,   1'b1},
    '{ 16'sd32767,  16'sd32767, 8'd11,  8'd254, 1'b0},
    '{-16'sd1,      16'sd1,     8'd0,   8'd0,   1'b0},
    '{-16'sd32768,  16'sd12000, 8'd13,  8'd100, 1'b0}
  };

  // Expected output from the requirement R1/R2 arithmetic, computed with reals.
  function automatic int exp_scale(input int x, input int code);
    int k, s, b;
    longint g, p, r;
    if (code >= 255) return 0;
    k = code % 12;
    s = code / 12;
    b = $rtoi(65536.0 * $pow(10.0, -real'(k) / 40.0) + 0.5);
    g = longint'(b) >> s;
    p = longint'(x) * g;
    r = (p + 64'sd32768) >>> 16;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input int a, input int b, output int ya, output int yb,
                        output int ostb);
    @(negedge clk);
    smp_l_in = 16'(a);
    smp_r_in = 16'(b);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    ya = int'(smp_l_out);
    yb = int'(smp_r_out);
    ostb = int'(smp_out_stb);
  endtask

  task automatic settle();
    int ya, yb, os;
    for (int i = 0; i < 260; i++) strobe(0, 0, ya, yb, os);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ya, yb, os;
    int el, er, p, cl, cr;

    // R9: reset state at the ports.
    atten_l = 8'd30;
    repeat (3) @(negedge clk);
    chk("R9 reset left out", int'(smp_l_out), 0);
    chk("R9 reset right out", int'(smp_r_out), 0);
    chk("R9 reset out strobe", int'(smp_out_stb), 0);
    rst_n = 1'b1;
    @(negedge clk);
    strobe(20000, -7000, ya, yb, os);
    chk("R9 first sample at unity left", ya, 20000);
    chk("R9 first sample at unity right", yb, -7000);
    chk("R2 output strobe follows", os, 1);

    // R1 R2 R3: vector table, each entry after the level has settled.
    for (int i = 0; i < NVEC; i++) begin
      atten_l = VECS[i].cl;
      atten_r = VECS[i].cr;
      link_en = VECS[i].lk;
      settle();
      strobe(int'(VECS[i].sl), int'(VECS[i].sr), ya, yb, os);
      cr = VECS[i].lk ? int'(VECS[i].cl) : int'(VECS[i].cr);
      chk($sformatf("R1 R2 vec %0d left", i), ya, exp_scale(int'(VECS[i].sl), int'(VECS[i].cl)));
      chk($sformatf("R1 R3 vec %0d right", i), yb, exp_scale(int'(VECS[i].sr), cr));
    end
    link_en = 1'b0;

    // R4: one code per strobe, sample uses the level before the step.
    atten_l = 8'd0;
    atten_r = 8'd0;
    settle();
    atten_l = 8'd5;
    for (int j = 0; j < 8; j++) begin
      strobe(20000, 20000, ya, yb, os);
      cl = (j < 5) ? j : 5;
      chk($sformatf("R4 step %0d left", j), ya, exp_scale(20000, cl));
      chk($sformatf("R4 step %0d right", j), yb, 20000);
    end

    // R5 R6: 1024-period soft mute from levels 100 and 40.
    atten_l = 8'd100;
    atten_r = 8'd40;
    mute_time = 2'b00;
    settle();
    softmute = 1'b1;
    for (int k = 0; k <= 1030; k++) begin
      strobe(20000, -15000, ya, yb, os);
      p = (k < 1024) ? k : 1024;
      el = 100 + (155 * p) / 1024;
      er = 40 + (215 * p) / 1024;
      chk($sformatf("R6 R5 mute ramp %0d left", k), ya, exp_scale(20000, el));
      chk($sformatf("R6 R5 mute ramp %0d right", k), yb, exp_scale(-15000, er));
    end

    // R8: code change while muted has no effect at the output.
    atten_l = 8'd0;
    mute_time = 2'b11;
    for (int k = 0; k < 3; k++) begin
      strobe(30000, 30000, ya, yb, os);
      chk("R8 muted with new code left", ya, 0);
      chk("R8 muted with new code right", yb, 0);
    end

    // R7 R5 R8: release over 128 periods, clamped phase, then track new code.
    softmute = 1'b0;
    for (int j = 0; j <= 130; j++) begin
      strobe(20000, 20000, ya, yb, os);
      p = (j < 128) ? 128 - j : 0;
      el = (j <= 128) ? 100 + (155 * p) / 128 : 100 - (j - 128);
      er = 40 + (215 * p) / 128;
      chk($sformatf("R7 R8 release %0d left", j), ya, exp_scale(20000, el));
      chk($sformatf("R7 R5 release %0d right", j), yb, exp_scale(20000, er));
    end

    // R10: idle cycles leave the outputs alone.
    strobe(12345, -12345, ya, yb, os);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 idle out strobe low", int'(smp_out_stb), 0);
      chk("R10 idle left hold", int'(smp_l_out), ya);
      chk("R10 idle right hold", int'(smp_r_out), yb);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule